// File: doc/BRIEF.md
# Receive Parallel Bit-Slip Aligner

This block shifts the bit alignment of a parallel receive word so that a word-boundary search further downstream can try every possible alignment. Each clock it takes a W-bit word. It keeps the word from the previous clock and builds a 2W-bit window with the current word in the upper half and the previous word in the lower half. It then registers the W bits that start at the current offset. A rising edge on the slip request moves that offset up by one bit, and the offset wraps from W-1 back to 0.

Slip requests must be spaced apart. After a request is accepted, a guard window of MIN_GAP cycles follows, and any new rising edge inside that window is dropped. A dropped edge sets a violation flag that stays set until reset.

The request logic is a two-state machine:
- ARMED is the reset state. A rising edge in ARMED is accepted. This transition is called *accept*: it increments the offset, starts the guard timer at 1 and moves the machine to GUARD.
- GUARD counts cycles. A rising edge in GUARD is *rejected*: it sets the violation flag. When the timer reaches MIN_GAP-1, the *rearm* transition returns the machine to ARMED.

A separate transmit path uses the same window structure. Its offset is taken directly from an input value each cycle.

Top module: `bsa_top`

## Requirements
- R1: While reset is held, and on leaving it, the offset is 0, the violation flag is 0, both valid outputs are 0 and both data outputs are 0.
- R2: A rising edge of the slip request accepted at clock edge k makes the offset output one higher after edge k.
- R3: A request held high for many cycles produces exactly one slip.
- R4: An accepted slip when the offset is W-1 sets the offset to 0.
- R5: After a slip accepted at edge k, rising edges at edges k+1 to k+MIN_GAP-1 leave the offset unchanged. A rising edge at edge k+MIN_GAP or later is accepted.
- R6: A rejected rising edge sets the violation flag, and the flag stays at 1 until reset.
- R7: At each edge the receive output takes bits [off+W-1:off] of {current input word, previous input word}. Here off is the offset held before that edge, so a slip accepted at the same edge first affects the next word.
- R8: The first output word after reset has valid 0. Every later word has valid 1, and valid stays at 1 until reset. This applies to both paths.
- R9: At each edge the transmit output takes bits [s+W-1:s] of {current transmit word, previous transmit word}, where s is the slip value input at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | W | Receive parallel word |
| rx_slip_req_i | input | 1 | Slip request; each accepted rising edge slips one bit |
| rx_data_o | output | W | Realigned receive word |
| rx_valid_o | output | 1 | Receive word valid |
| rx_offset_o | output | $clog2(W) | Current receive offset |
| slip_viol_o | output | 1 | Sticky flag for a request rejected by the spacing rule |
| tx_data_i | input | W | Transmit parallel word |
| tx_slip_i | input | $clog2(W) | Transmit slip amount |
| tx_data_o | output | W | Slipped transmit word |
| tx_valid_o | output | 1 | Transmit word valid |

## Verification
Two functions can act at the same edge: an accepted slip updates the offset, and the receive window selects a word with the offset. The bench produces this case on every slip by changing the data word on the same cycle that it raises the request. It expects that word to use the old offset and the following word to use the new one.

The bench also places rising edges exactly MIN_GAP-1 and MIN_GAP cycles after an accepted slip. Each edge is judged against an arithmetic model of the offset, the spacing rule and the violation flag.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // States of the slip request controller
    typedef enum logic {
        ST_ARMED = 1'b0,   // next rising edge is accepted
        ST_GUARD = 1'b1    // spacing window running, edges rejected
    } slip_state_e;

endpackage

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl #(
    parameter int unsigned W       = 64,
    parameter int unsigned MIN_GAP = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    output logic [$clog2(W)-1:0]  off_o,
    output logic                  viol_o
);
    import bsa_pkg::*;

    localparam int unsigned OW = $clog2(W);
    localparam int unsigned TW = $clog2(MIN_GAP);
    localparam logic [TW-1:0] LAST = TW'(MIN_GAP - 1);
    localparam logic [OW-1:0] TOP  = OW'(W - 1);

    slip_state_e   state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [OW-1:0] off_q, off_d;
    logic          viol_q, viol_d;
    logic          req_q;
    logic          rise;

    assign rise = req_i & ~req_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and the values it carries
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        off_d   = off_q;
        viol_d  = viol_q;
        unique case (state_q)
            ST_ARMED: begin
                if (rise) begin                       // accept
                    state_d = ST_GUARD;
                    tmr_d   = TW'(1);
                    off_d   = (off_q == TOP) ? '0 : off_q + 1'b1;
                end
            end
            ST_GUARD: begin
                if (rise) begin                       // reject
                    viol_d = 1'b1;
                end
                if (tmr_q == LAST) begin              // rearm
                    state_d = ST_ARMED;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            tmr_q  <= '0;
            off_q  <= '0;
            viol_q <= 1'b0;
        end else begin
            req_q  <= req_i;
            tmr_q  <= tmr_d;
            off_q  <= off_d;
            viol_q <= viol_d;
        end
    end

    assign off_o  = off_q;
    assign viol_o = viol_q;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && rise && off_q != TOP) |=> (off_q == $past(off_q) + 1'b1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && rise && off_q == TOP) |=> (off_q == '0));

    p_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && req_q) |=> (off_q == $past(off_q)));

    p_guard_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD) |=> (off_q == $past(off_q)));

    p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q <= LAST));

    p_viol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && rise) |=> viol_q);

    p_viol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

endmodule

// File: rtl/bsa_word_window.sv
module bsa_word_window #(
    parameter int unsigned W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          data_i,
    input  logic [$clog2(W)-1:0]  off_i,
    output logic [W-1:0]          data_o,
    output logic                  valid_o
);
    localparam int unsigned CW = 2 * W;

    logic [W-1:0]  prev_q;
    logic [W-1:0]  out_q;
    logic          fill_q;
    logic          valid_q;
    logic [CW-1:0] cat;
    logic [CW-1:0] shifted;

    always_comb begin
        cat     = {data_i, prev_q};
        shifted = cat >> off_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            out_q   <= '0;
            fill_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            prev_q  <= data_i;
            out_q   <= shifted[W-1:0];
            fill_q  <= 1'b1;
            valid_q <= fill_q;
        end
    end

    assign data_o  = out_q;
    assign valid_o = valid_q;

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);

    p_first_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(fill_q));

endmodule

// File: rtl/bsa_top.sv
module bsa_top #(
    parameter int unsigned W       = 64,
    parameter int unsigned MIN_GAP = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          rx_data_i,
    input  logic                  rx_slip_req_i,
    output logic [W-1:0]          rx_data_o,
    output logic                  rx_valid_o,
    output logic [$clog2(W)-1:0]  rx_offset_o,
    output logic                  slip_viol_o,
    input  logic [W-1:0]          tx_data_i,
    input  logic [$clog2(W)-1:0]  tx_slip_i,
    output logic [W-1:0]          tx_data_o,
    output logic                  tx_valid_o
);
    localparam int unsigned OW = $clog2(W);

    logic [OW-1:0] rx_off;

    bsa_slip_ctrl #(.W(W), .MIN_GAP(MIN_GAP)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (rx_slip_req_i),
        .off_o  (rx_off),
        .viol_o (slip_viol_o)
    );

    bsa_word_window #(.W(W)) rx_win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (rx_data_i),
        .off_i   (rx_off),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    bsa_word_window #(.W(W)) tx_win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (tx_data_i),
        .off_i   (tx_slip_i),
        .data_o  (tx_data_o),
        .valid_o (tx_valid_o)
    );

    assign rx_offset_o = rx_off;

    p_tx_valid_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o == tx_valid_o));

endmodule

// File: tb/bsa_top_tb.sv
module bsa_top_tb_top;
    localparam int W       = 8;
    localparam int OW      = 3;
    localparam int MIN_GAP = 20;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  rx_data_i = '0;
    logic          rx_slip_req_i = 1'b0;
    logic [W-1:0]  rx_data_o;
    logic          rx_valid_o;
    logic [OW-1:0] rx_offset_o;
    logic          slip_viol_o;
    logic [W-1:0]  tx_data_i = '0;
    logic [OW-1:0] tx_slip_i = '0;
    logic [W-1:0]  tx_data_o;
    logic          tx_valid_o;

    int errors = 0;
    int checks = 0;
    string tag_s = "R1";

    // bench model state
    int          m_off, m_last, m_cyc;
    logic        m_req, m_fill, m_viol;
    logic [W-1:0] m_prev, m_tprev;
    logic [W-1:0] e_rx, e_tx;
    logic        e_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsa_top #(.W(W), .MIN_GAP(MIN_GAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_data_i(rx_data_i), .rx_slip_req_i(rx_slip_req_i),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .rx_offset_o(rx_offset_o), .slip_viol_o(slip_viol_o),
        .tx_data_i(tx_data_i), .tx_slip_i(tx_slip_i),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_off = 0; m_last = -1000; m_cyc = 0;
        m_req = 0; m_fill = 0; m_viol = 0;
        m_prev = '0; m_tprev = '0;
        e_rx = '0; e_tx = '0; e_valid = 0;
    endtask

    task automatic check_all();
        chk("R7", "rx_data", int'(rx_data_o), int'(e_rx));
        chk("R8", "rx_valid", int'(rx_valid_o), int'(e_valid));
        chk("R9", "tx_data", int'(tx_data_o), int'(e_tx));
        chk("R8", "tx_valid", int'(tx_valid_o), int'(e_valid));
        chk(tag_s, "offset", int'(rx_offset_o), m_off);
        chk("R6", "viol", int'(slip_viol_o), int'(m_viol));
    endtask

    // called at a negedge: drive, model the coming edge, check at next negedge
    task automatic step(input logic [W-1:0] rd, input logic rq,
                        input logic [W-1:0] td, input logic [OW-1:0] ts);
        logic [2*W-1:0] c;
        logic rise;
        rx_data_i = rd; rx_slip_req_i = rq; tx_data_i = td; tx_slip_i = ts;
        m_cyc++;
        rise = rq & ~m_req;
        c = {rd, m_prev} >> m_off;
        e_rx = c[W-1:0];
        c = {td, m_tprev} >> ts;
        e_tx = c[W-1:0];
        e_valid = m_fill;
        if (rise) begin
            if (m_cyc - m_last >= MIN_GAP) begin
                m_off = (m_off + 1) % W;
                m_last = m_cyc;
            end else begin
                m_viol = 1'b1;
            end
        end
        m_req = rq; m_prev = rd; m_tprev = td; m_fill = 1'b1;
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_data_i = '0; rx_slip_req_i = 0; tx_data_i = '0; tx_slip_i = '0;
        repeat (3) @(negedge clk);
        chk("R1", "offset in reset", int'(rx_offset_o), 0);
        chk("R1", "viol in reset", int'(slip_viol_o), 0);
        chk("R1", "rx_valid in reset", int'(rx_valid_o), 0);
        chk("R1", "tx_valid in reset", int'(tx_valid_o), 0);
        chk("R1", "rx_data in reset", int'(rx_data_o), 0);
        chk("R1", "tx_data in reset", int'(tx_data_o), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(W'($urandom), 1'b0, W'($urandom), OW'($urandom));
    endtask

    // n-1 quiet cycles, then one request cycle
    task automatic pulse_after(input int n);
        for (int i = 0; i < n - 1; i++) step(W'($urandom), 1'b0, W'($urandom), '0);
        step(W'($urandom), 1'b1, W'($urandom), '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R9: every transmit slip value with varied data
        tag_s = "R9";
        for (int s = 0; s < W; s++)
            for (int k = 0; k < 6; k++) step(W'($urandom), 1'b0, W'($urandom), OW'(s));
        step(8'hFF, 1'b0, 8'h00, 3'd7);
        step(8'h00, 1'b0, 8'hFF, 3'd1);

        // R2, R4, R7: walk the offset through all values and wrap
        tag_s = "R2";
        for (int s = 0; s < W + 1; s++) begin
            tag_s = (m_off == W - 1) ? "R4" : "R2";
            step(W'($urandom), 1'b1, W'($urandom), OW'(s));
            for (int k = 0; k < MIN_GAP + 3; k++)
                step(W'(k * 37 + s), 1'b0, W'($urandom), OW'(s));
        end

        // R3: held request gives a single slip
        tag_s = "R3";
        for (int k = 0; k < 60; k++) step(W'($urandom), 1'b1, W'($urandom), '0);
        idle(25);

        // R5: edge at last guard cycle rejected, edge at MIN_GAP accepted
        tag_s = "R5";
        pulse_after(1);
        pulse_after(MIN_GAP - 1);
        idle(30);
        pulse_after(1);
        pulse_after(MIN_GAP);
        pulse_after(5);
        idle(30);

        // R6: flag remains after long quiet time
        tag_s = "R6";
        idle(50);
        chk("R6", "viol sticky", int'(slip_viol_o), 1);

        // R1: reset mid-run with nonzero offset
        tag_s = "R1";
        pulse_after(1);
        idle(25);
        do_reset();
        step(8'hA5, 1'b0, 8'h5A, 3'd2);
        step(8'h3C, 1'b0, 8'hC3, 3'd2);
        idle(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule